// File: doc/BRIEF.md
# Phase-Tagged Peak Hold Detector

This block follows up to three signed 24-bit phase sample streams. For each selected phase it keeps the largest absolute value seen during a measurement window. The window length is a programmable count of half line cycles. Every zero-crossing strobe from a selected phase advances the count by one. Selecting more phases therefore makes the window shorter in time, because more crossings arrive per line period.

When a window closes, the block writes a 32-bit result word in one step. The word holds the unsigned peak magnitude and a one-hot tag naming the phase that produced that peak. The word then holds still until the next window closes. A chip uses one instance for the voltage channels and a second instance for the current channels. Zero-crossing detection and register access sit outside the block.

Top module: `peak_hold_top`

## Requirements
- R1: The window closes in the cycle where the number of selected zero-crossing strobes, counted since the last close, reaches `winLen`. The result word is registered on that clock edge and is visible in the following cycle.
- R2: Each selected phase whose `zcStrobe` bit is high adds one to the count. Two selected phases that strobe in the same cycle add two.
- R3: A phase whose `phaseSel` bit is low has no effect. Its samples never enter the peak, and its zero-crossing strobes do not advance the count.
- R4: Bits 23:0 of `peakWord` hold the absolute value of the winning sample as an unsigned number.
- R5: Bits 26:24 of `peakWord` are the tag: bit 24 is phase A (index 0), bit 25 is phase B, and bit 26 is phase C. At most one tag bit is set. Bits 31:27 are always zero.
- R6: The running maximum is cleared when each window closes. If a window sees no nonzero selected sample, it reports an all-zero word. The tag is nonzero exactly when the magnitude is nonzero.
- R7: `peakWord` does not change in any cycle other than a window close.
- R8: The sample 0x800000 (most negative value) gives magnitude 0x7FFFFF. Bit 23 of the magnitude is never set.
- R9: While `winLen` is 0, no window closes and `peakWord` keeps its last value.
- R10: On equal magnitudes, the tag stays with the phase that reached the value first. Within a single cycle, the lower phase index wins.
- R11: After reset, `peakWord` is zero and the half-cycle count is zero.
- R12: A valid selected sample that arrives in the same cycle as the closing strobe is included in the closing window.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| sampleA | input | 24 | Phase A signed sample |
| sampleB | input | 24 | Phase B signed sample |
| sampleC | input | 24 | Phase C signed sample |
| sampleValid | input | 3 | Per-phase sample valid (bit 0 = A) |
| zcStrobe | input | 3 | Per-phase zero-crossing strobe (bit 0 = A) |
| phaseSel | input | 3 | Per-phase participation select (bit 0 = A) |
| winLen | input | 8 | Window length in half line cycles; 0 disables updates |
| peakWord | output | 32 | Latched result: zero pad, tag, magnitude |

## Verification
The assertions check the result word's format on every cycle: the pad bits are zero, the tag has at most one bit set, the tag agrees with the magnitude, and magnitude bit 23 is never set. They also check that the word holds whenever no selected crossing arrives or the window length is zero, and that a window never closes without a selected strobe. Some behaviours need chosen sample sequences, and only the bench scenarios show them:
- the exact cycle in which a window closes when several phases strobe together;
- that the winning value is the right one;
- how ties are resolved;
- that deselected phases are left out;
- that the most negative sample saturates.

// File: rtl/peak_hold_pkg.sv
package peak_hold_pkg;
  // Strobes passed from control to datapath each cycle
  typedef struct packed {
    logic winEnd;   // current window closes on this edge
    logic idle;     // window length of zero: no closes
  } ctrlStrobe_t;
endpackage

// File: rtl/peak_hold_ctrl.sv
module peak_hold_ctrl
  import peak_hold_pkg::*;
#(
  parameter int PHASES = 3,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [PHASES-1:0] zcStrobe,
  input  logic [PHASES-1:0] phaseSel,
  input  logic [CYC_W-1:0]  winLen,
  output ctrlStrobe_t       strb
);
  localparam int SUM_W = CYC_W + $clog2(PHASES + 1);

  logic [CYC_W-1:0] halfCnt;
  logic [SUM_W-1:0] zcInc;
  logic [SUM_W-1:0] sumCnt;

  always_comb begin
    zcInc = '0;
    for (int i = 0; i < PHASES; i++) begin
      if (zcStrobe[i] && phaseSel[i]) zcInc = zcInc + SUM_W'(1);
    end
    sumCnt      = SUM_W'(halfCnt) + zcInc;
    strb.idle   = (winLen == '0);
    strb.winEnd = !strb.idle && (sumCnt >= SUM_W'(winLen));
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      halfCnt <= '0;
    end else if (strb.idle || strb.winEnd) begin
      halfCnt <= '0;
    end else begin
      halfCnt <= sumCnt[CYC_W-1:0];
    end
  end
endmodule

// File: rtl/peak_hold_datapath.sv
module peak_hold_datapath
  import peak_hold_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int PHASES = 3,
  parameter int WORD_W = 32
) (
  input  logic                     clk,
  input  logic                     rstN,
  input  logic [PHASES*DATA_W-1:0] samples,
  input  logic [PHASES-1:0]        sampleValid,
  input  logic [PHASES-1:0]        phaseSel,
  input  ctrlStrobe_t              strb,
  output logic [WORD_W-1:0]        resultWord
);
  localparam int PAD_W = WORD_W - PHASES - DATA_W;
  localparam logic [DATA_W-1:0] MOST_NEG = {1'b1, {(DATA_W-1){1'b0}}};
  localparam logic [DATA_W-1:0] MAG_MAX  = {1'b0, {(DATA_W-1){1'b1}}};

  logic [DATA_W-1:0] magArr [PHASES];
  logic [DATA_W-1:0] runMag, bestMag;
  logic [PHASES-1:0] runTag, bestTag;

  // Saturating absolute value per phase
  for (genvar g = 0; g < PHASES; g++) begin : gAbs
    logic [DATA_W-1:0] slice;
    assign slice = samples[g*DATA_W +: DATA_W];
    always_comb begin
      if (slice == MOST_NEG)      magArr[g] = MAG_MAX;
      else if (slice[DATA_W-1])   magArr[g] = -slice;
      else                        magArr[g] = slice;
    end
  end

  // Strict compare chain: running value wins ties, then lower index
  always_comb begin
    bestMag = runMag;
    bestTag = runTag;
    for (int i = 0; i < PHASES; i++) begin
      if (sampleValid[i] && phaseSel[i] && (magArr[i] > bestMag)) begin
        bestMag = magArr[i];
        bestTag = PHASES'(1) << i;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      runMag     <= '0;
      runTag     <= '0;
      resultWord <= '0;
    end else if (strb.winEnd) begin
      resultWord <= {{PAD_W{1'b0}}, bestTag, bestMag};
      runMag     <= '0;
      runTag     <= '0;
    end else begin
      runMag <= bestMag;
      runTag <= bestTag;
    end
  end
endmodule

// File: rtl/peak_hold_top.sv
module peak_hold_top
  import peak_hold_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CYC_W  = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [DATA_W-1:0] sampleA,
  input  logic [DATA_W-1:0] sampleB,
  input  logic [DATA_W-1:0] sampleC,
  input  logic [2:0]        sampleValid,
  input  logic [2:0]        zcStrobe,
  input  logic [2:0]        phaseSel,
  input  logic [CYC_W-1:0]  winLen,
  output logic [31:0]       peakWord
);
  localparam int PHASES = 3;
  localparam int WORD_W = 32;

  ctrlStrobe_t strb;

  peak_hold_ctrl #(.PHASES(PHASES), .CYC_W(CYC_W)) uCtrl (
    .clk(clk), .rstN(rstN), .zcStrobe(zcStrobe), .phaseSel(phaseSel),
    .winLen(winLen), .strb(strb)
  );

  peak_hold_datapath #(.DATA_W(DATA_W), .PHASES(PHASES), .WORD_W(WORD_W)) uDp (
    .clk(clk), .rstN(rstN), .samples({sampleC, sampleB, sampleA}),
    .sampleValid(sampleValid), .phaseSel(phaseSel), .strb(strb),
    .resultWord(peakWord)
  );
endmodule

// File: rtl/peak_hold_checker.sv
module peak_hold_checker
  import peak_hold_pkg::*;
#(
  parameter int DATA_W = 24,
  parameter int CYC_W  = 8
) (
  input logic             clk,
  input logic             rstN,
  input logic [2:0]       zcStrobe,
  input logic [2:0]       phaseSel,
  input logic [CYC_W-1:0] winLen,
  input logic [31:0]      peakWord,
  input ctrlStrobe_t      strb
);
  logic [2:0]        tagBits;
  logic [DATA_W-1:0] magBits;
  assign tagBits = peakWord[DATA_W+2:DATA_W];
  assign magBits = peakWord[DATA_W-1:0];

  AST_HOLD_NO_ZC: assert property (@(posedge clk) disable iff (!rstN)
    ((zcStrobe & phaseSel) == 3'b000) |=> $stable(peakWord)); // R7
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    (winLen == '0) |=> $stable(peakWord)); // R9
  AST_END_NEEDS_ZC: assert property (@(posedge clk) disable iff (!rstN)
    strb.winEnd |-> ((zcStrobe & phaseSel) != 3'b000)); // R1
  AST_TAG_ONEHOT: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(tagBits)); // R5
  AST_PAD_ZERO: assert property (@(posedge clk) disable iff (!rstN)
    peakWord[31:DATA_W+3] == '0); // R5
  AST_MAG_SAT: assert property (@(posedge clk) disable iff (!rstN)
    !magBits[DATA_W-1]); // R8
  AST_TAG_MATCH: assert property (@(posedge clk) disable iff (!rstN)
    ((tagBits != 3'b000) == (magBits != '0))); // R6
endmodule

bind peak_hold_top peak_hold_checker #(.DATA_W(DATA_W), .CYC_W(CYC_W)) uChk (
  .clk(clk), .rstN(rstN), .zcStrobe(zcStrobe), .phaseSel(phaseSel),
  .winLen(winLen), .peakWord(peakWord), .strb(strb)
);

// File: tb/peak_hold_top_test.sv
`timescale 1ns/1ps
module peak_hold_top_test;
  logic        clk = 1'b0;
  logic        rstN;
  logic [23:0] sampleA, sampleB, sampleC;
  logic [2:0]  sampleValid, zcStrobe, phaseSel;
  logic [7:0]  winLen;
  logic [31:0] peakWord;

  int checkCnt = 0;
  int failCnt  = 0;
  bit done     = 1'b0;

  always #2.5 clk = ~clk;

  peak_hold_top uut (
    .clk(clk), .rstN(rstN), .sampleA(sampleA), .sampleB(sampleB),
    .sampleC(sampleC), .sampleValid(sampleValid), .zcStrobe(zcStrobe),
    .phaseSel(phaseSel), .winLen(winLen), .peakWord(peakWord)
  );

  function automatic logic [31:0] mk(input logic [2:0] tag, input logic [23:0] mag);
    return {5'b0, tag, mag};
  endfunction

  task automatic chk(input string req, input logic [31:0] exp);
    checkCnt++;
    if (peakWord !== exp) begin
      failCnt++;
      $display("FAIL %s: peakWord got %h expected %h", req, peakWord, exp);
    end
  endtask

  // Drive one cycle of inputs; returns at the next falling edge
  task automatic drive(input logic [23:0] a, input logic [23:0] b, input logic [23:0] c,
                       input logic [2:0] v, input logic [2:0] zc);
    sampleA = a; sampleB = b; sampleC = c; sampleValid = v; zcStrobe = zc;
    @(negedge clk);
  endtask

  task automatic testReset();
    chk("R11 reset", 32'h0);
  endtask

  task automatic testBasic();
    phaseSel = 3'b001; winLen = 8'd2;
    drive(24'd100, 0, 0, 3'b001, 3'b000);
    drive(-24'sd500, 0, 0, 3'b001, 3'b000);
    drive(24'd300, 0, 0, 3'b001, 3'b001);
    chk("R7 mid-window hold", 32'h0);
    drive(-24'sd600, 0, 0, 3'b001, 3'b001);
    chk("R1 R4 R12 close with same-cycle sample", mk(3'b001, 24'd600));
  endtask

  task automatic testNextWindow();
    drive(24'd50, 0, 0, 3'b001, 3'b001);
    chk("R7 previous result held", mk(3'b001, 24'd600));
    drive(0, 0, 0, 3'b000, 3'b001);
    chk("R6 max cleared per window", mk(3'b001, 24'd50));
  endtask

  task automatic testMultiPhase();
    phaseSel = 3'b011; winLen = 8'd4;
    drive(24'd10, 24'h003000, 0, 3'b011, 3'b011);
    chk("R2 two strobes count two, not yet closed", mk(3'b001, 24'd50));
    drive(24'd20, -24'sh004000, 0, 3'b011, 3'b011);
    chk("R2 window closes after four strobes", mk(3'b010, 24'h004000));
  endtask

  task automatic testDeselected();
    phaseSel = 3'b001; winLen = 8'd2;
    for (int k = 0; k < 3; k++) drive(0, 0, 24'h7FFF00, 3'b100, 3'b100);
    chk("R3 deselected strobes ignored", mk(3'b010, 24'h004000));
    drive(24'd5, 0, 24'h7FFF00, 3'b101, 3'b001);
    drive(0, 0, 0, 3'b000, 3'b001);
    chk("R3 deselected samples ignored", mk(3'b001, 24'd5));
  endtask

  task automatic testSaturate();
    phaseSel = 3'b111; winLen = 8'd1;
    drive(0, 0, 24'h800000, 3'b100, 3'b100);
    chk("R8 most negative saturates", mk(3'b100, 24'h7FFFFF));
  endtask

  task automatic testTies();
    drive(24'd1000, 24'd1000, -24'sd1000, 3'b111, 3'b000);
    drive(0, 0, 0, 3'b000, 3'b010);
    chk("R10 same-cycle tie lower index", mk(3'b001, 24'd1000));
    drive(0, 24'd2000, 0, 3'b010, 3'b000);
    drive(-24'sd2000, 0, 0, 3'b001, 3'b000);
    drive(0, 0, 24'd2000, 3'b100, 3'b001);
    chk("R10 earlier arrival keeps tag", mk(3'b010, 24'd2000));
  endtask

  task automatic testEmpty();
    drive(0, 0, 0, 3'b000, 3'b001);
    chk("R6 empty window gives zero", 32'h0);
    drive(0, 0, 0, 3'b111, 3'b100);
    chk("R6 zero samples give zero tag", 32'h0);
  endtask

  task automatic testIdle();
    drive(24'd77, 0, 0, 3'b001, 3'b001);
    chk("R1 single-cycle window", mk(3'b001, 24'd77));
    winLen = 8'd0;
    for (int k = 0; k < 3; k++) begin
      drive(24'd900, 24'd900, 0, 3'b011, 3'b111);
      chk("R9 length zero holds result", mk(3'b001, 24'd77));
    end
  endtask

  initial begin
    rstN = 1'b0; sampleA = 0; sampleB = 0; sampleC = 0;
    sampleValid = 0; zcStrobe = 0; phaseSel = 0; winLen = 0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    testReset();
    testBasic();
    testNextWindow();
    testMultiPhase();
    testDeselected();
    testSaturate();
    testTies();
    testEmpty();
    testIdle();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checkCnt++;
      failCnt++;
      $display("FAIL watchdog: run did not complete, got hang expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checkCnt, failCnt);
      $finish;
    end
  end
endmodule